// File: doc/BRIEF.md
# Integer Arithmetic Logic Unit with Signed Less-Than

This block is a purely combinational integer arithmetic logic unit for a datapath of configurable width, 32 bits by default. It takes two two's-complement operands and a 3-bit operation code, and it returns a result word of the same width. It also returns three flags: result-is-zero, signed overflow, and the carry out of the top adder stage. The result is ready in the same cycle the inputs are applied. It holds no state, so it needs neither a clock nor a reset.

The datapath is a chain of identical one-bit slices. Each slice computes AND, OR and a full-adder sum of its operand bits and picks one of them. Subtraction uses the same adder: the upper bit of the operation code inverts every B bit and also sets the carry into bit 0, so the chain forms A + ~B + 1. For the signed less-than compare, the chain performs a subtraction. Bit 0 of the result then takes the top sum bit corrected by the overflow condition, and every other result bit is forced to 0.

Top module: `int_alu`

## Requirements
- R1: Operation code 3'b000 gives result = A AND B, bit by bit.
- R2: Operation code 3'b001 gives result = A OR B, bit by bit.
- R3: Operation code 3'b010 gives result = (A + B) mod 2^WIDTH.
- R4: Operation code 3'b110 gives result = (A - B) mod 2^WIDTH, formed as A + ~B + 1.
- R5: Operation code 3'b111 gives a result whose bit 0 is 1 exactly when A < B as signed two's-complement values, and whose other bits are all 0. The compare stays correct when A - B overflows.
- R6: For codes 3'b010 and 3'b110, the overflow flag is 1 exactly when the true signed sum or difference lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1].
- R7: For codes 3'b000, 3'b001 and 3'b111, the overflow flag is 0.
- R8: The zero flag is 1 exactly when every result bit is 0, for every operation code.
- R9: For codes 3'b000, 3'b001 and 3'b010, the carry flag equals bit WIDTH of the unsigned sum A + B.
- R10: For codes 3'b110 and 3'b111, the carry flag is 1 exactly when A >= B as unsigned values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand (A) |
| b_i | input | WIDTH | Second operand (B) |
| op_i | input | 3 | Operation code |
| result_o | output | WIDTH | Result word |
| zero_o | output | 1 | All result bits are 0 |
| overflow_o | output | 1 | Signed overflow of add or subtract |
| carry_o | output | 1 | Carry out of the top adder stage |

## Verification
The bench builds two copies of the block. The first uses WIDTH = 32 and is driven with directed corner operands and a few hundred random pairs. The second uses WIDTH = 4, where all 256 operand pairs under all five operation codes can be applied. This covers every overflow boundary, every signed-compare case that crosses the sign bit, and every carry combination at that width. Each output is compared with a reference model written from the requirements using wide integer arithmetic.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [2:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  // slice output select = op[1:0]
  localparam logic [1:0] SEL_AND  = 2'b00;
  localparam logic [1:0] SEL_OR   = 2'b01;
  localparam logic [1:0] SEL_SUM  = 2'b10;
  localparam logic [1:0] SEL_LESS = 2'b11;
endpackage

// File: rtl/int_alu_slice.sv
module int_alu_slice
  import int_alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       inv_i,
  input  logic       c_i,
  input  logic       less_i,
  input  logic [1:0] sel_i,
  output logic       y_o,
  output logic       c_o
);
  logic b_eff, sum;

  assign b_eff = b_i ^ inv_i;
  assign sum   = a_i ^ b_eff ^ c_i;
  assign c_o   = (a_i & b_eff) | (c_i & (a_i ^ b_eff));

  always_comb begin
    unique case (sel_i)
      SEL_AND: y_o = a_i & b_eff;
      SEL_OR:  y_o = a_i | b_eff;
      SEL_SUM: y_o = sum;
      default: y_o = less_i;
    endcase
  end
endmodule

// File: rtl/int_alu_chain.sv
module int_alu_chain #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] y_o,
  output logic             carry_o,
  output logic             ovf_raw_o
);
  logic             inv;
  logic [WIDTH:0]   c;
  logic [WIDTH-1:0] less;
  logic             msb_sum;

  assign inv  = op_i[2];
  assign c[0] = inv;

  // top sum bit, corrected for signed overflow, feeds the less-than input of bit 0
  assign msb_sum   = a_i[WIDTH-1] ^ b_i[WIDTH-1] ^ inv ^ c[WIDTH-1];
  assign ovf_raw_o = c[WIDTH] ^ c[WIDTH-1];
  assign less      = {{(WIDTH-1){1'b0}}, msb_sum ^ ovf_raw_o};
  assign carry_o   = c[WIDTH];

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    int_alu_slice u_slice (
      .a_i   (a_i[i]),
      .b_i   (b_i[i]),
      .inv_i (inv),
      .c_i   (c[i]),
      .less_i(less[i]),
      .sel_i (op_i[1:0]),
      .y_o   (y_o[i]),
      .c_o   (c[i+1])
    );
  end
endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] y_i,
  input  logic [2:0]       op_i,
  input  logic             ovf_raw_i,
  output logic             zero_o,
  output logic             overflow_o
);
  logic arith;

  assign arith      = (op_i == OP_ADD) || (op_i == OP_SUB);
  assign overflow_o = arith & ovf_raw_i;
  assign zero_o     = ~|y_i;
endmodule

// File: rtl/int_alu.sv
module int_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             overflow_o,
  output logic             carry_o
);
  logic ovf_raw;

  int_alu_chain #(.WIDTH(WIDTH)) u_chain (
    .a_i      (a_i),
    .b_i      (b_i),
    .op_i     (op_i),
    .y_o      (result_o),
    .carry_o  (carry_o),
    .ovf_raw_o(ovf_raw)
  );

  int_alu_flags #(.WIDTH(WIDTH)) u_flags (
    .y_i       (result_o),
    .op_i      (op_i),
    .ovf_raw_i (ovf_raw),
    .zero_o    (zero_o),
    .overflow_o(overflow_o)
  );
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             overflow_o,
  input logic             carry_o
);
  logic [WIDTH-1:0] slt_ref;

  assign slt_ref = {{(WIDTH-1){1'b0}}, ($signed(a_i) < $signed(b_i))};

  always_comb begin
    // R3
    if (op_i == OP_ADD) add_sum_chk: assert (result_o == a_i + b_i);
    // R4
    if (op_i == OP_SUB) sub_diff_chk: assert (result_o == a_i - b_i);
    // R5
    if (op_i == OP_SLT) slt_value_chk: assert (result_o == slt_ref);
    // R7
    if (op_i == OP_AND || op_i == OP_OR || op_i == OP_SLT) no_overflow_chk: assert (!overflow_o);
    // R8
    if (op_i == OP_SUB && a_i == b_i) equal_zero_chk: assert (zero_o);
    // R10
    if (op_i == OP_SUB) sub_carry_chk: assert (carry_o == (a_i >= b_i));
  end
endmodule

bind int_alu int_alu_chk #(.WIDTH(WIDTH)) u_int_alu_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .op_i      (op_i),
  .result_o  (result_o),
  .zero_o    (zero_o),
  .overflow_o(overflow_o),
  .carry_o   (carry_o)
);

// File: tb/int_alu_bench.sv
module int_alu_bench;
  localparam int W32 = 32;
  localparam int W4  = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W32-1:0] a32, b32, r32;
  logic [2:0]     op32;
  logic           z32, v32, c32;
  logic [W4-1:0]  a4, b4, r4;
  logic [2:0]     op4;
  logic           z4, v4, c4;

  int checks = 0;
  int fails  = 0;

  int_alu #(.WIDTH(W32)) u_int_alu (
    .a_i(a32), .b_i(b32), .op_i(op32),
    .result_o(r32), .zero_o(z32), .overflow_o(v32), .carry_o(c32)
  );

  int_alu #(.WIDTH(W4)) u_int_alu_n4 (
    .a_i(a4), .b_i(b4), .op_i(op4),
    .result_o(r4), .zero_o(z4), .overflow_o(v4), .carry_o(c4)
  );

  task automatic check(input string req, input longint unsigned got, input longint unsigned exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // reference model from the requirements, any width up to 32
  task automatic apply(input int w, input longint unsigned a, input longint unsigned b, input logic [2:0] op);
    longint unsigned mask, sum, res, sgn, sa, sb, dif;
    logic ovf, cy;
    string rt;
    mask = (64'd1 << w) - 1;
    a &= mask; b &= mask;
    sgn  = 64'd1 << (w - 1);
    sum  = a + b;
    dif  = (a - b) & mask;
    sa = a ^ sgn; sb = b ^ sgn;   // offset binary: unsigned order = signed order
    ovf = 1'b0;
    case (op)
      3'b000: begin res = a & b; rt = "R1"; cy = sum[w]; end
      3'b001: begin res = a | b; rt = "R2"; cy = sum[w]; end
      3'b010: begin
        res = sum & mask; rt = "R3"; cy = sum[w];
        ovf = ((a & sgn) == (b & sgn)) && ((res & sgn) != (a & sgn));
      end
      3'b110: begin
        res = dif; rt = "R4"; cy = (a >= b);
        ovf = ((a & sgn) != (b & sgn)) && ((res & sgn) != (a & sgn));
      end
      default: begin res = (sa < sb) ? 64'd1 : 64'd0; rt = "R5"; cy = (a >= b); end
    endcase
    @(posedge clk);
    if (w == W32) begin a32 = a[31:0]; b32 = b[31:0]; op32 = op; end
    else          begin a4 = a[3:0];   b4 = b[3:0];   op4 = op; end
    @(negedge clk);
    if (w == W32) begin
      check(rt, r32, res);
      check((op == 3'b010 || op == 3'b110) ? "R6" : "R7", v32, ovf);
      check("R8", z32, res == 0);
      check((op == 3'b110 || op == 3'b111) ? "R10" : "R9", c32, cy);
    end else begin
      check(rt, r4, res);
      check((op == 3'b010 || op == 3'b110) ? "R6" : "R7", v4, ovf);
      check("R8", z4, res == 0);
      check((op == 3'b110 || op == 3'b111) ? "R10" : "R9", c4, cy);
    end
  endtask

  task automatic t_idle;
    // R8: all-zero operands under AND give a zero result with the flag set
    apply(W32, 0, 0, 3'b000);
    apply(W4, 0, 0, 3'b000);
  endtask

  task automatic t_logic;  // R1 R2
    apply(W32, 64'hF0F0_A5A5, 64'h0FF0_FFFF, 3'b000);
    apply(W32, 64'hF0F0_A5A5, 64'h0FF0_0000, 3'b001);
    apply(W32, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 3'b000);
    apply(W32, 64'h5555_5555, 64'hAAAA_AAAA, 3'b000);
  endtask

  task automatic t_add;  // R3 R6 R9
    apply(W32, 64'h7FFF_FFFF, 1, 3'b010);
    apply(W32, 64'h8000_0000, 64'h8000_0000, 3'b010);
    apply(W32, 64'hFFFF_FFFF, 1, 3'b010);
    apply(W32, 3, 2, 3'b010);
  endtask

  task automatic t_sub;  // R4 R6 R10
    apply(W32, 64'h8000_0000, 1, 3'b110);
    apply(W32, 64'h7FFF_FFFF, 64'hFFFF_FFFF, 3'b110);
    apply(W32, 5, 5, 3'b110);
    apply(W32, 2, 7, 3'b110);
  endtask

  task automatic t_slt;  // R5 R7 R10
    apply(W32, 64'h8000_0000, 64'h7FFF_FFFF, 3'b111);
    apply(W32, 64'h7FFF_FFFF, 64'h8000_0000, 3'b111);
    apply(W32, 64'hFFFF_FFFF, 0, 3'b111);
    apply(W32, 9, 9, 3'b111);
  endtask

  task automatic t_exhaustive_n4;  // R1..R10 over all 4-bit pairs
    logic [2:0] ops [5] = '{3'b000, 3'b001, 3'b010, 3'b110, 3'b111};
    for (int k = 0; k < 5; k++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          apply(W4, a, b, ops[k]);
  endtask

  task automatic t_random32;
    logic [2:0] ops [5] = '{3'b000, 3'b001, 3'b010, 3'b110, 3'b111};
    for (int n = 0; n < 400; n++)
      apply(W32, {32'd0, $urandom}, {32'd0, $urandom}, ops[n % 5]);
  endtask

  initial begin
    a32 = '0; b32 = '0; op32 = '0;
    a4 = '0; b4 = '0; op4 = '0;
    repeat (2) @(posedge clk);
    t_idle();
    t_logic();
    t_add();
    t_sub();
    t_slt();
    t_exhaustive_n4();
    t_random32();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule